// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor core that completes every instruction in a single clock cycle. In one cycle it fetches the word at the program counter, splits it into fields, reads two source registers, runs the ALU, optionally reads or writes a word of data storage, and writes the result back. Register file, program counter and data storage change at the rising edge that closes the cycle. All reads are combinational, so any result written at an edge is visible to the instruction in the next cycle.

Instruction storage and data storage are kept apart, so a fetch and a data access can both happen in the same cycle. Both are small internal arrays. The program image is given as a parameter. The core executes register-to-register ALU operations, set-on-less-than with an immediate, word loads and stores, and branch-on-equal. Its outputs trace the instruction in flight: the fetch address, the instruction word, the register write, the store and the branch decision. An embedding testbench or a trace monitor can follow execution from these outputs.

Top module: `sc_core`

## Requirements
- R1: A rising edge with `rst_n` low sets the program counter to 0; the register file is cleared and no register or data word is written in that cycle.
- R2: When no branch is taken, the program counter advances by 4 at each rising edge.
- R3: An instruction with opcode (bits 31:26) 0x00 and shift field (bits 10:6) zero writes register rd (bits 15:11) with rs (bits 25:21) op rt (bits 20:16). The function field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x27 nor, 0x2A signed set-less-than.
- R4: Opcode 0x0A writes register rt with 1 when rs is less than the sign-extended 16-bit immediate (bits 15:0), compared as signed numbers, and with 0 otherwise.
- R5: Opcode 0x23 writes rt with the data word at byte address rs + sign-extended immediate. Opcode 0x2B writes the value of rt to that address and raises `dmem_we_o`, with the address on `dmem_addr_o` and the value on `dmem_wdata_o`.
- R6: Opcode 0x04 subtracts rt from rs. When the difference is zero it raises `branch_taken_o`, and the next program counter is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next program counter is PC+4.
- R7: Register 0 always reads as zero; a write addressed to it has no effect.
- R8: Stores and branches never assert `wb_en_o`; only opcode 0x2B asserts `dmem_we_o`.
- R9: A register written by one instruction supplies the new value to the instruction in the next cycle.
- R10: Any other opcode, an R-type word with a non-zero shift field, or an unlisted function code writes nothing, stores nothing and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_o | output | 32 | Byte address of the instruction in flight |
| instr_o | output | 32 | Instruction word fetched at `pc_o` |
| wb_en_o | output | 1 | The instruction in flight writes a register |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value written back |
| dmem_we_o | output | 1 | The instruction in flight stores a word |
| dmem_addr_o | output | 32 | Byte address computed by the ALU |
| dmem_wdata_o | output | 32 | Value of the second source register |
| branch_taken_o | output | 1 | A branch-on-equal is taken this cycle |

## Verification
The outputs for the instruction at `pc_o` are combinational. They are valid within the same cycle in which that instruction is fetched, before the rising edge that commits it. The register file, data storage and program counter take one edge to change. Their effect is seen in the next cycle, either as a new `pc_o` or as an operand of the next instruction. The bench drives the reset and samples every output at the falling edge, halfway between commits. It compares one table entry per cycle. Each taken branch is checked through the `pc_o` of the entry that follows it, and each load or dependent operation through the value that comes back one cycle after the producing write.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
// Package sc_pkg
// Shared encodings and control types for the single-cycle core.
// Assumes the fixed 32-bit instruction word with 6-bit opcode and function fields.
package sc_pkg;

    localparam int XLEN      = 32;
    localparam int NUM_REGS  = 32;
    localparam int REG_IDX_W = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND,
        ALU_OR,
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_NOR
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;  // result goes to the register file
        logic    dst_rd;     // destination is rd (else rt)
        logic    imm_b;      // ALU second operand is the immediate
        logic    mem_rd;     // write-back comes from data storage
        logic    mem_wr;     // store a word
        logic    branch;     // branch-on-equal
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        reg_write: 1'b0,
        dst_rd:    1'b0,
        imm_b:     1'b0,
        mem_rd:    1'b0,
        mem_wr:    1'b0,
        branch:    1'b0,
        alu_op:    ALU_ADD
    };

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
// Module sc_decode
// Turns opcode, shift and function fields into the control bundle.
// Assumes unsupported encodings must be harmless: they decode to CTRL_NOP.
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] shamt,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Purpose: map each supported encoding to its datapath settings.
    always_comb begin
        ctrl = CTRL_NOP;
        case (opcode)
            OP_RTYPE: begin
                if (shamt == 5'd0) begin
                    ctrl.reg_write = 1'b1;
                    ctrl.dst_rd    = 1'b1;
                    case (funct)
                        FN_ADD:  ctrl.alu_op = ALU_ADD;
                        FN_SUB:  ctrl.alu_op = ALU_SUB;
                        FN_AND:  ctrl.alu_op = ALU_AND;
                        FN_OR:   ctrl.alu_op = ALU_OR;
                        FN_NOR:  ctrl.alu_op = ALU_NOR;
                        FN_SLT:  ctrl.alu_op = ALU_SLT;
                        default: ctrl = CTRL_NOP;
                    endcase
                end
            end
            OP_SLTI: begin
                ctrl.reg_write = 1'b1;
                ctrl.imm_b     = 1'b1;
                ctrl.alu_op    = ALU_SLT;
            end
            OP_LW: begin
                ctrl.reg_write = 1'b1;
                ctrl.imm_b     = 1'b1;
                ctrl.mem_rd    = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            OP_SW: begin
                ctrl.imm_b  = 1'b1;
                ctrl.mem_wr = 1'b1;
                ctrl.alu_op = ALU_ADD;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
// Module sc_alu
// Combinational ALU with a zero flag used by branch-on-equal.
// Assumes set-less-than compares both operands as two's complement.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Purpose: compute the selected function of the two operands.
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
// Module sc_regfile
// Two combinational read ports, one write port updated on the rising edge.
// Assumes entry 0 is hard-wired to zero; synchronous active-low reset clears all.
module sc_regfile
    import sc_pkg::*;
#(
    parameter int N = NUM_REGS,
    parameter int W = XLEN,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [N-1:0][W-1:0] regs;

    assign regs[0] = '0;

    for (genvar g = 1; g < N; g++) begin : g_reg
        logic [W-1:0] q;
        // Purpose: hold one architectural register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == IW'(g))) begin
                q <= wdata;
            end
        end
        assign regs[g] = q;
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/sc_dmem.sv
`timescale 1ns/1ps
// Module sc_dmem
// Word-wide data storage: combinational read, write on the rising edge.
// Assumes word addressing; out-of-range reads give zero and stores there are dropped.
module sc_dmem
    import sc_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int W     = XLEN,
    localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [29:0]  word_addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);

    localparam logic [29:0] LIMIT = 30'(WORDS);

    logic [W-1:0]  mem [WORDS];
    logic          in_range;
    logic [AW-1:0] idx;

    assign in_range = (word_addr < LIMIT);
    assign idx      = word_addr[AW-1:0];

    // Purpose: commit a store at the end of the cycle.
    always_ff @(posedge clk) begin
        if (rst_n && we && in_range) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = in_range ? mem[idx] : '0;

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
// Module sc_core
// Single-cycle core: fetch, decode and register read, execute, data access
// and write-back all happen in one clock period.
// Assumes the program image arrives through PROGRAM (word i at bits i*32+:32);
// fetch beyond the image returns zero, which decodes as a no-op.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 16,
    parameter logic [IMEM_WORDS*32-1:0] PROGRAM = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] pc_o,
    output logic [31:0] instr_o,
    output logic        wb_en_o,
    output logic [4:0]  wb_idx_o,
    output logic [31:0] wb_data_o,
    output logic        dmem_we_o,
    output logic [31:0] dmem_addr_o,
    output logic [31:0] dmem_wdata_o,
    output logic        branch_taken_o
);

    localparam int          IAW    = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1;
    localparam logic [29:0] ILIMIT = 30'(IMEM_WORDS);

    // ---- fetch ----
    logic [29:0] pc_w_q;
    logic [29:0] pc_w_next;
    logic [31:0] rom [IMEM_WORDS];
    logic [31:0] instr;

    for (genvar g = 0; g < IMEM_WORDS; g++) begin : g_rom
        assign rom[g] = PROGRAM[g*32 +: 32];
    end

    // Purpose: read the instruction word at the current word address.
    always_comb begin
        instr = '0;
        if (pc_w_q < ILIMIT) begin
            instr = rom[pc_w_q[IAW-1:0]];
        end
    end

    // ---- decode and register read ----
    logic [4:0]  rs_idx, rt_idx, rd_idx, dst_idx;
    logic [31:0] imm_sext;
    logic [31:0] rs_val, rt_val;
    ctrl_t       ctrl;

    assign rs_idx   = instr[25:21];
    assign rt_idx   = instr[20:16];
    assign rd_idx   = instr[15:11];
    assign imm_sext = {{16{instr[15]}}, instr[15:0]};
    assign dst_idx  = ctrl.dst_rd ? rd_idx : rt_idx;

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .shamt  (instr[10:6]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    logic [31:0] wb_data;

    sc_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .we      (ctrl.reg_write),
        .waddr   (dst_idx),
        .wdata   (wb_data),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    // ---- execute ----
    logic [31:0] alu_b;
    logic [31:0] alu_y;
    logic        alu_zero;

    assign alu_b = ctrl.imm_b ? imm_sext : rt_val;

    sc_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // ---- data access ----
    logic [31:0] load_val;

    sc_dmem #(.WORDS(DMEM_WORDS)) u_dmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctrl.mem_wr),
        .word_addr (alu_y[31:2]),
        .wdata     (rt_val),
        .rdata     (load_val)
    );

    // ---- write-back and next address ----
    logic taken;

    assign wb_data   = ctrl.mem_rd ? load_val : alu_y;
    assign taken     = ctrl.branch & alu_zero;
    assign pc_w_next = pc_w_q + 30'd1 + (taken ? imm_sext[29:0] : 30'd0);

    // Purpose: hold the word address of the instruction in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_w_q <= '0;
        end else begin
            pc_w_q <= pc_w_next;
        end
    end

    assign pc_o           = {pc_w_q, 2'b00};
    assign instr_o        = instr;
    assign wb_en_o        = ctrl.reg_write;
    assign wb_idx_o       = dst_idx;
    assign wb_data_o      = wb_data;
    assign dmem_we_o      = ctrl.mem_wr;
    assign dmem_addr_o    = alu_y;
    assign dmem_wdata_o   = rt_val;
    assign branch_taken_o = taken;

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
// Module sc_core_chk
// Port-level properties of the single-cycle core; attached by bind below.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_o,
    input logic [31:0] instr_o,
    input logic        wb_en_o,
    input logic        dmem_we_o,
    input logic        branch_taken_o
);

    logic [5:0] op;
    logic       known_op;
    logic       rst_q = 1'b0;

    assign op       = instr_o[31:26];
    assign known_op = (op == 6'h00) || (op == 6'h0A) || (op == 6'h23) ||
                      (op == 6'h2B) || (op == 6'h04);

    // Purpose: remember whether the last rising edge saw reset.
    always @(posedge clk) rst_q <= !rst_n;

    // Purpose: PC must read zero after a reset edge.
    always @(negedge clk) begin
        if (rst_q) begin
            a_r1_reset_pc: assert (pc_o == 32'd0)
                else $error("pc not zero after reset");
        end
    end

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !branch_taken_o |=> pc_o == $past(pc_o) + 32'd4);

    a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken_o |=> pc_o == $past(pc_o) + 32'd4 +
            {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00});

    a_r6_taken_only_beq: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken_o |-> op == 6'h04);

    a_r8_no_wb_store_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h2B || op == 6'h04) |-> !wb_en_o);

    a_r8_store_only_sw: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we_o |-> op == 6'h2B);

    a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!wb_en_o && !dmem_we_o && !branch_taken_o));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pc_o           (pc_o),
    .instr_o        (instr_o),
    .wb_en_o        (wb_en_o),
    .dmem_we_o      (dmem_we_o),
    .branch_taken_o (branch_taken_o)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

    localparam int IMEM_WORDS = 32;
    localparam int NTRACE     = 27;

    function automatic logic [31:0] enc_r(logic [4:0] rd, logic [4:0] rs,
                                          logic [4:0] rt, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt,
                                          logic [4:0] rs, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] prog_word(int i);
        case (i)
            0:  return enc_i(6'h0A, 5'd1, 5'd0, 16'd5);       // slti r1 = (0<5)
            1:  return enc_i(6'h0A, 5'd5, 5'd0, 16'hFFFD);    // slti r5 = (0<-3)
            2:  return enc_r(5'd2, 5'd1, 5'd1, 6'h20);        // add
            3:  return enc_r(5'd3, 5'd2, 5'd1, 6'h20);        // add, uses r2 just written
            4:  return enc_r(5'd4, 5'd0, 5'd0, 6'h27);        // nor
            5:  return enc_r(5'd6, 5'd1, 5'd2, 6'h22);        // sub
            6:  return enc_r(5'd7, 5'd4, 5'd1, 6'h2A);        // slt -1<1
            7:  return enc_r(5'd8, 5'd4, 5'd3, 6'h24);        // and
            8:  return enc_r(5'd9, 5'd2, 5'd1, 6'h25);        // or
            9:  return enc_i(6'h0A, 5'd10, 5'd4, 16'd0);      // slti -1<0
            10: return enc_r(5'd0, 5'd1, 5'd1, 6'h20);        // write to r0
            11: return enc_r(5'd11, 5'd0, 5'd1, 6'h20);       // read r0
            12: return enc_i(6'h2B, 5'd3, 5'd2, 16'd6);       // sw r3 -> 8
            13: return enc_i(6'h2B, 5'd2, 5'd4, 16'd13);      // sw r2 -> 12
            14: return enc_i(6'h23, 5'd12, 5'd0, 16'd8);      // lw from 8
            15: return enc_r(5'd13, 5'd3, 5'd3, 6'h20);
            16: return enc_r(5'd14, 5'd13, 5'd13, 6'h20);
            17: return enc_i(6'h23, 5'd15, 5'd14, 16'hFFFC);  // lw 12-4
            18: return enc_i(6'h23, 5'd16, 5'd14, 16'd0);     // lw 12
            19: return enc_i(6'h04, 5'd2, 5'd1, 16'd5);       // beq not taken
            20: return enc_i(6'h04, 5'd8, 5'd3, 16'd2);       // beq taken -> 92
            21: return enc_r(5'd17, 5'd1, 5'd1, 6'h20);       // skipped
            22: return enc_r(5'd18, 5'd1, 5'd1, 6'h20);       // skipped
            23: return 32'hFC00_0000;                         // unknown opcode
            24: return enc_r(5'd18, 5'd1, 5'd2, 6'h00);       // unlisted funct
            25: return enc_r(5'd19, 5'd1, 5'd4, 6'h2A);       // slt 1<-1
            26: return enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);    // beq to self
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [IMEM_WORDS*32-1:0] build_prog();
        logic [IMEM_WORDS*32-1:0] p;
        p = '0;
        for (int i = 0; i < IMEM_WORDS; i++) p[i*32 +: 32] = prog_word(i);
        return p;
    endfunction

    localparam logic [IMEM_WORDS*32-1:0] PROG = build_prog();

    typedef struct packed {
        logic [31:0] pc;
        logic        bt;
        logic        wbe;
        logic [4:0]  widx;
        logic [31:0] wdat;
        logic [1:0]  mem;     // 0 none, 1 store, 2 load
        logic [31:0] maddr;
        logic [31:0] mdat;
    } exp_t;

    localparam exp_t EXP [NTRACE] = '{
        '{32'd0,   1'b0, 1'b1, 5'd1,  32'd1,          2'd0, 32'd0,  32'd0}, // R4
        '{32'd4,   1'b0, 1'b1, 5'd5,  32'd0,          2'd0, 32'd0,  32'd0}, // R4 signed imm
        '{32'd8,   1'b0, 1'b1, 5'd2,  32'd2,          2'd0, 32'd0,  32'd0}, // R3
        '{32'd12,  1'b0, 1'b1, 5'd3,  32'd3,          2'd0, 32'd0,  32'd0}, // R9
        '{32'd16,  1'b0, 1'b1, 5'd4,  32'hFFFF_FFFF,  2'd0, 32'd0,  32'd0}, // R3 nor
        '{32'd20,  1'b0, 1'b1, 5'd6,  32'hFFFF_FFFF,  2'd0, 32'd0,  32'd0}, // R3 sub
        '{32'd24,  1'b0, 1'b1, 5'd7,  32'd1,          2'd0, 32'd0,  32'd0}, // R3 slt
        '{32'd28,  1'b0, 1'b1, 5'd8,  32'd3,          2'd0, 32'd0,  32'd0}, // R3 and
        '{32'd32,  1'b0, 1'b1, 5'd9,  32'd3,          2'd0, 32'd0,  32'd0}, // R3 or
        '{32'd36,  1'b0, 1'b1, 5'd10, 32'd1,          2'd0, 32'd0,  32'd0}, // R4
        '{32'd40,  1'b0, 1'b1, 5'd0,  32'd2,          2'd0, 32'd0,  32'd0}, // R7 write r0
        '{32'd44,  1'b0, 1'b1, 5'd11, 32'd1,          2'd0, 32'd0,  32'd0}, // R7 r0 still 0
        '{32'd48,  1'b0, 1'b0, 5'd0,  32'd0,          2'd1, 32'd8,  32'd3}, // R5 store
        '{32'd52,  1'b0, 1'b0, 5'd0,  32'd0,          2'd1, 32'd12, 32'd2}, // R5 store
        '{32'd56,  1'b0, 1'b1, 5'd12, 32'd3,          2'd2, 32'd8,  32'd0}, // R5 load
        '{32'd60,  1'b0, 1'b1, 5'd13, 32'd6,          2'd0, 32'd0,  32'd0}, // R3
        '{32'd64,  1'b0, 1'b1, 5'd14, 32'd12,         2'd0, 32'd0,  32'd0}, // R3
        '{32'd68,  1'b0, 1'b1, 5'd15, 32'd3,          2'd2, 32'd8,  32'd0}, // R5 negative offset
        '{32'd72,  1'b0, 1'b1, 5'd16, 32'd2,          2'd2, 32'd12, 32'd0}, // R5
        '{32'd76,  1'b0, 1'b0, 5'd0,  32'd0,          2'd0, 32'd0,  32'd0}, // R6 not taken
        '{32'd80,  1'b1, 1'b0, 5'd0,  32'd0,          2'd0, 32'd0,  32'd0}, // R6 taken
        '{32'd92,  1'b0, 1'b0, 5'd0,  32'd0,          2'd0, 32'd0,  32'd0}, // R10 (R6 target)
        '{32'd96,  1'b0, 1'b0, 5'd0,  32'd0,          2'd0, 32'd0,  32'd0}, // R10 funct
        '{32'd100, 1'b0, 1'b1, 5'd19, 32'd0,          2'd0, 32'd0,  32'd0}, // R3 slt false
        '{32'd104, 1'b1, 1'b0, 5'd0,  32'd0,          2'd0, 32'd0,  32'd0}, // R6 backward
        '{32'd104, 1'b1, 1'b0, 5'd0,  32'd0,          2'd0, 32'd0,  32'd0}, // R6 self loop
        '{32'd104, 1'b1, 1'b0, 5'd0,  32'd0,          2'd0, 32'd0,  32'd0}  // R6 self loop
    };

    function automatic string tag_of(int k);
        case (k)
            0, 1, 9:                 return "R4";
            3:                       return "R9";
            10, 11:                  return "R7";
            12, 13, 14, 17, 18:      return "R5";
            19, 20, 24, 25, 26:      return "R6";
            21, 22:                  return "R10";
            default:                 return "R3";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_o, instr_o, wb_data_o, dmem_addr_o, dmem_wdata_o;
    logic        wb_en_o, dmem_we_o, branch_taken_o;
    logic [4:0]  wb_idx_o;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    sc_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(16), .PROGRAM(PROG)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .pc_o           (pc_o),
        .instr_o        (instr_o),
        .wb_en_o        (wb_en_o),
        .wb_idx_o       (wb_idx_o),
        .wb_data_o      (wb_data_o),
        .dmem_we_o      (dmem_we_o),
        .dmem_addr_o    (dmem_addr_o),
        .dmem_wdata_o   (dmem_wdata_o),
        .branch_taken_o (branch_taken_o)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_entry(int k);
        exp_t  e;
        string t;
        e = EXP[k];
        t = tag_of(k);
        check("R2", "pc", pc_o, e.pc);
        check("R6", "branch_taken", 32'(branch_taken_o), 32'(e.bt));
        check("R8", "wb_en", 32'(wb_en_o), 32'(e.wbe));
        check("R8", "dmem_we", 32'(dmem_we_o), 32'(e.mem == 2'd1));
        if (e.wbe) begin
            check(t, "wb_idx", 32'(wb_idx_o), 32'(e.widx));
            check(t, "wb_data", wb_data_o, e.wdat);
        end
        if (e.mem != 2'd0) check(t, "mem_addr", dmem_addr_o, e.maddr);
        if (e.mem == 2'd1) check(t, "store_data", dmem_wdata_o, e.mdat);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "pc in reset", pc_o, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < NTRACE; k++) begin
            check_entry(k);
            @(negedge clk);
        end
        // Directed: reset in the middle of the self loop.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "pc after mid-run reset", pc_o, 32'd0);
        @(negedge clk);
        check("R1", "pc held in reset", pc_o, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check_entry(k);
            @(negedge clk);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule